// File: doc/BRIEF.md
# Data Tenure Scheduler with Write Bypass

This block keeps a short ordered queue of data-bus tenures that are waiting to run, each marked as a read or a write and carrying a small tag. When the system hands the block a qualified data-bus grant while the bus is idle, the block takes the bus and chooses the tenure to run. Without a sideband override it takes the oldest entry. When the write-only override is raised with the grant, the oldest queued write runs first, ahead of any older reads. If no write is queued, the oldest read runs instead. The override exists mainly so that a burst copyback can leave before a read that is waiting.

The chosen tenure is removed from the queue, and the entries behind it close up in their original order. Its tag and type are held on the outputs until the next accepted grant. A busy indication covers the tenure, from the cycle after the grant until the cycle after the completion strobe. A two-state controller drives this. In `ST_IDLE` the bus is free. The transition *accept* (grant, no tenure in progress, queue not empty) moves the controller to `ST_XFER`. The transition *complete* (completion strobe) returns it to `ST_IDLE`. Reset is synchronous and all inputs are sampled on the rising clock edge.

Top module: `dtn_sched`

## Requirements
- R1: A grant seen in `ST_IDLE` with at least one entry queued always starts a tenure: `busy` is 1 from the next cycle, and `cur_tag`/`cur_is_wr` (1 = write, 0 = read) show the chosen entry from that same cycle.
- R2: With `wr_only` low at the grant, the oldest queued entry is chosen, whatever its type.
- R3: With `wr_only` high at the grant and at least one write queued, the oldest queued write is chosen, even when older reads are queued.
- R4: With `wr_only` high at the grant and no write queued, the oldest queued read is chosen and the bus is still taken.
- R5: A grant that arrives while `busy` is 1 has no effect: the queue contents, `cur_tag` and `cur_is_wr` are unchanged.
- R6: A grant that arrives while the queue is empty has no effect: `busy` stays 0 and `cur_tag`/`cur_is_wr` keep their values.
- R7: `busy` falls in the cycle after `done` is seen in `ST_XFER`. A `done` seen in `ST_IDLE` has no effect.
- R8: The queue holds DEPTH (default 4) entries. `full` is 1 when DEPTH entries are queued and `empty` is 1 when none are. An enqueue while `full` is 1 is rejected: `enq_reject` is 1 in that cycle and the queue contents are unchanged.
- R9: When a write is taken from the middle of the queue, the remaining entries keep their relative order for later grants.
- R10: A synchronous reset empties the queue, drops `busy`, and clears `cur_tag` and `cur_is_wr` to 0.
- R11: An enqueue in the same cycle as an accepted grant is kept. The new entry is placed behind the entries that remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| enq_valid | input | 1 | Enqueue a pending tenure this cycle |
| enq_is_wr | input | 1 | Type of the enqueued tenure, 1 = write |
| enq_tag | input | TAG_W | Tag of the enqueued tenure |
| grant | input | 1 | Qualified data-bus grant |
| wr_only | input | 1 | Write-only override, sampled with grant |
| done | input | 1 | Current tenure has completed |
| busy | output | 1 | Block holds the data bus for a tenure |
| cur_tag | output | TAG_W | Tag of the most recently started tenure |
| cur_is_wr | output | 1 | Type of the most recently started tenure |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entries |
| enq_reject | output | 1 | Enqueue this cycle is refused because the queue is full |

## Verification
The bench builds the block with DEPTH = 4 and TAG_W = 4, the default values. At this depth four enqueues fill the queue, so rejection, taking a write from the tail, and taking a write from the middle of a full queue all occur within a few cycles. Four-bit tags give each tenure in a sequence its own value, so any reordering or loss of an entry changes an observed tag.

// File: rtl/dtn_pkg.sv
package dtn_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } dtn_state_e;
endpackage

// File: rtl/dtn_queue.sv
module dtn_queue #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             push_wr,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             pop,
    input  logic [IDX_W-1:0] pop_idx,
    output logic [TAG_W-1:0] slot_tag [DEPTH],
    output logic             slot_wr  [DEPTH],
    output logic [CNT_W-1:0] count
);
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic             wr_q  [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [TAG_W-1:0] tag_d [DEPTH];
    logic             wr_d  [DEPTH];
    logic [CNT_W-1:0] cnt_left;

    assign cnt_left = cnt_q - CNT_W'(pop);

    // Close the gap left by a removed entry, then append at the tail.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (pop && (i >= int'(pop_idx))) begin
                if (i < DEPTH - 1) begin
                    tag_d[i] = tag_q[(i + 1 < DEPTH) ? i + 1 : i];
                    wr_d[i]  = wr_q[(i + 1 < DEPTH) ? i + 1 : i];
                end else begin
                    tag_d[i] = '0;
                    wr_d[i]  = 1'b0;
                end
            end else begin
                tag_d[i] = tag_q[i];
                wr_d[i]  = wr_q[i];
            end
            if (push && (i == int'(cnt_left))) begin
                tag_d[i] = push_tag;
                wr_d[i]  = push_wr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                tag_q[i] <= '0;
                wr_q[i]  <= 1'b0;
            end
            cnt_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                tag_q[i] <= tag_d[i];
                wr_q[i]  <= wr_d[i];
            end
            cnt_q <= cnt_left + CNT_W'(push);
        end
    end

    assign slot_tag = tag_q;
    assign slot_wr  = wr_q;
    assign count    = cnt_q;
endmodule

// File: rtl/dtn_pick.sv
module dtn_pick #(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             slot_wr [DEPTH],
    input  logic [CNT_W-1:0] count,
    input  logic             wr_only,
    output logic [IDX_W-1:0] sel_idx
);
    logic             wr_found;
    logic [IDX_W-1:0] wr_idx;

    // Lowest occupied slot holding a write is the oldest write.
    always_comb begin
        wr_found = 1'b0;
        wr_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (slot_wr[i] && (i < int'(count))) begin
                wr_found = 1'b1;
                wr_idx   = IDX_W'(i);
            end
        end
        sel_idx = (wr_only && wr_found) ? wr_idx : '0;
    end
endmodule

// File: rtl/dtn_sched.sv
module dtn_sched
    import dtn_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TAG_W = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enq_valid,
    input  logic             enq_is_wr,
    input  logic [TAG_W-1:0] enq_tag,
    input  logic             grant,
    input  logic             wr_only,
    input  logic             done,
    output logic             busy,
    output logic [TAG_W-1:0] cur_tag,
    output logic             cur_is_wr,
    output logic             full,
    output logic             empty,
    output logic             enq_reject
);
    dtn_state_e       state_q, state_d;
    logic [TAG_W-1:0] slot_tag [DEPTH];
    logic             slot_wr  [DEPTH];
    logic [CNT_W-1:0] count;
    logic [IDX_W-1:0] sel_idx;
    logic             accept;
    logic             push;
    logic [TAG_W-1:0] tag_q;
    logic             wr_q;

    assign full       = (count == CNT_W'(DEPTH));
    assign empty      = (count == '0);
    assign push       = enq_valid && !full;
    assign enq_reject = enq_valid && full;
    assign accept     = (state_q == ST_IDLE) && grant && !empty;

    dtn_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_wr  (enq_is_wr),
        .push_tag (enq_tag),
        .pop      (accept),
        .pop_idx  (sel_idx),
        .slot_tag (slot_tag),
        .slot_wr  (slot_wr),
        .count    (count)
    );

    dtn_pick #(.DEPTH(DEPTH)) u_pick (
        .slot_wr (slot_wr),
        .count   (count),
        .wr_only (wr_only),
        .sel_idx (sel_idx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_XFER;
            ST_XFER: if (done)   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
            wr_q  <= 1'b0;
        end else if (accept) begin
            tag_q <= slot_tag[sel_idx];
            wr_q  <= slot_wr[sel_idx];
        end
    end

    assign busy      = (state_q == ST_XFER);
    assign cur_tag   = tag_q;
    assign cur_is_wr = wr_q;
endmodule

// File: rtl/dtn_sched_chk.sv
module dtn_sched_chk #(
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             enq_valid,
    input logic             grant,
    input logic             done,
    input logic             busy,
    input logic [TAG_W-1:0] cur_tag,
    input logic             cur_is_wr,
    input logic             full,
    input logic             empty
);
    p_start_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && grant && !empty) |=> busy);

    p_busy_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && $stable(cur_tag) && $stable(cur_is_wr)));

    p_empty_grant_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && grant && empty) |=> (!busy && $stable(cur_tag)));

    p_busy_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && done) |=> !busy);

    p_flags_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({full, empty}));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (full && enq_valid && !(grant && !busy)) |=> full);
endmodule

bind dtn_sched dtn_sched_chk #(.TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enq_valid (enq_valid),
    .grant     (grant),
    .done      (done),
    .busy      (busy),
    .cur_tag   (cur_tag),
    .cur_is_wr (cur_is_wr),
    .full      (full),
    .empty     (empty)
);

// File: tb/tb_dtn_sched.sv
module tb_dtn_sched;
    localparam int DEPTH = 4;
    localparam int TAG_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enq_valid = 1'b0;
    logic             enq_is_wr = 1'b0;
    logic [TAG_W-1:0] enq_tag = '0;
    logic             grant = 1'b0;
    logic             wr_only = 1'b0;
    logic             done = 1'b0;
    logic             busy;
    logic [TAG_W-1:0] cur_tag;
    logic             cur_is_wr;
    logic             full;
    logic             empty;
    logic             enq_reject;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dtn_sched #(.DEPTH(DEPTH), .TAG_W(TAG_W)) dut (
        .clk        (clk),
        .rst        (rst),
        .enq_valid  (enq_valid),
        .enq_is_wr  (enq_is_wr),
        .enq_tag    (enq_tag),
        .grant      (grant),
        .wr_only    (wr_only),
        .done       (done),
        .busy       (busy),
        .cur_tag    (cur_tag),
        .cur_is_wr  (cur_is_wr),
        .full       (full),
        .empty      (empty),
        .enq_reject (enq_reject)
    );

    typedef struct packed {
        logic       ev;
        logic       ew;
        logic [3:0] et;
        logic       g;
        logic       wo;
        logic       d;
        logic       xb;
        logic [3:0] xt;
        logic       xw;
        logic       xe;
        logic       xf;
        logic [7:0] req;
    } vec_t;

    // Inputs for one cycle, then the expected busy/tag/type/empty/full after that edge.
    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{1,0,4'h1, 0,0,0, 0,4'h0,0,0,0, 8}, // R8 enqueue read 1
        '{1,1,4'h2, 0,0,0, 0,4'h0,0,0,0, 8}, // R8 write 2
        '{1,0,4'h3, 0,0,0, 0,4'h0,0,0,0, 8}, // R8 read 3
        '{1,1,4'h4, 0,0,0, 0,4'h0,0,0,1, 8}, // R8 write 4 -> full
        '{1,0,4'h5, 0,0,0, 0,4'h0,0,0,1, 8}, // R8 rejected enqueue
        '{0,0,4'h0, 1,0,0, 1,4'h1,0,0,0, 2}, // R2 oldest, read 1
        '{0,0,4'h0, 1,1,0, 1,4'h1,0,0,0, 5}, // R5 grant while busy
        '{0,0,4'h0, 0,0,1, 0,4'h1,0,0,0, 7}, // R7 done
        '{0,0,4'h0, 1,1,0, 1,4'h2,1,0,0, 3}, // R3 write 2
        '{0,0,4'h0, 0,0,1, 0,4'h2,1,0,0, 7}, // R7
        '{0,0,4'h0, 1,1,0, 1,4'h4,1,0,0, 3}, // R3 write 4 passes read 3
        '{1,0,4'h6, 0,0,1, 0,4'h4,1,0,0, 7}, // R7 done + enqueue read 6
        '{0,0,4'h0, 1,1,0, 1,4'h3,0,0,0, 4}, // R4 override, no write
        '{0,0,4'h0, 0,0,1, 0,4'h3,0,0,0, 7}, // R7
        '{1,1,4'h7, 1,0,0, 1,4'h6,0,0,0, 11}, // R11 grant + enqueue
        '{0,0,4'h0, 0,0,1, 0,4'h6,0,0,0, 7}, // R7
        '{0,0,4'h0, 1,0,0, 1,4'h7,1,1,0, 11}, // R11 appended write 7
        '{0,0,4'h0, 0,0,1, 0,4'h7,1,1,0, 7}, // R7
        '{0,0,4'h0, 1,1,0, 0,4'h7,1,1,0, 6}, // R6 grant on empty queue
        '{1,0,4'h8, 0,0,0, 0,4'h7,1,0,0, 9}, // R9 fill
        '{1,1,4'h9, 0,0,0, 0,4'h7,1,0,0, 9},
        '{1,0,4'hA, 0,0,0, 0,4'h7,1,0,0, 9},
        '{1,1,4'hB, 0,0,0, 0,4'h7,1,0,1, 9},
        '{0,0,4'h0, 1,1,0, 1,4'h9,1,0,0, 3}, // R3 middle write 9
        '{0,0,4'h0, 0,0,1, 0,4'h9,1,0,0, 7},
        '{0,0,4'h0, 1,0,0, 1,4'h8,0,0,0, 9}, // R9 read 8 next
        '{0,0,4'h0, 0,0,1, 0,4'h8,0,0,0, 7},
        '{0,0,4'h0, 1,0,0, 1,4'hA,0,0,0, 9}, // R9 read A next
        '{0,0,4'h0, 0,0,1, 0,4'hA,0,0,0, 7},
        '{0,0,4'h0, 1,0,0, 1,4'hB,1,1,0, 9}, // R9 write B last
        '{0,0,4'h0, 0,0,1, 0,4'hB,1,1,0, 7},
        '{0,0,4'h0, 0,0,1, 0,4'hB,1,1,0, 7}  // R7 done while idle
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] outs();
        return {1'b0, busy, cur_tag, cur_is_wr, empty, full};
    endfunction

    task automatic drive(input logic ev, input logic ew, input logic [3:0] et,
                         input logic g, input logic wo, input logic d);
        enq_valid = ev; enq_is_wr = ew; enq_tag = et;
        grant = g; wr_only = wo; done = d;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 reset state", outs(), {1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0});

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k].ev, VEC[k].ew, VEC[k].et, VEC[k].g, VEC[k].wo, VEC[k].d);
            @(posedge clk);
            #2;
            check($sformatf("R%0d vector %0d", VEC[k].req, k), outs(),
                  {1'b0, VEC[k].xb, VEC[k].xt, VEC[k].xw, VEC[k].xe, VEC[k].xf});
            @(negedge clk);
        end

        // R8: reject flag and queue contents across an overflow attempt.
        drive(1, 0, 4'hC, 0, 0, 0);
        #1;
        check("R8 no reject when not full", {7'b0, enq_reject}, 8'h00);
        for (int t = 12; t < 16; t++) begin
            drive(1, 0, 4'(t), 0, 0, 0);
            @(negedge clk);
        end
        drive(1, 1, 4'h1, 0, 0, 0);
        #1;
        check("R8 reject when full", {7'b0, enq_reject}, 8'h01);
        @(negedge clk);
        drive(0, 0, 4'h0, 0, 0, 0);
        for (int t = 12; t < 16; t++) begin
            drive(0, 0, 4'h0, 1, 1, 0);
            @(negedge clk);
            check("R8 contents after reject", outs(),
                  {1'b0, 1'b1, 4'(t), 1'b0, (t == 15), 1'b0});
            drive(0, 0, 4'h0, 0, 0, 1);
            @(negedge clk);
        end

        // R10: reset in the middle of a tenure.
        drive(1, 1, 4'h5, 0, 0, 0);
        @(negedge clk);
        drive(1, 1, 4'h6, 1, 0, 0);
        @(negedge clk);
        drive(0, 0, 4'h0, 0, 0, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 reset during tenure", outs(), {1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0});

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule